// File: doc/BRIEF.md
# Line-State Directory Controller for Broadcast Ownership Coherence

This block tracks coherence ownership of memory lines for a broadcast protocol. It keeps a small table indexed by line number. Each entry holds a line state and a one-transaction record that remembers which kind of data response is pending. Three input channels come into the block:
- cache requests: read-shared, read-exclusive and put;
- cache completion messages: unblock and four kinds of writeback;
- memory replies: read data and write acknowledge.

Three output channels go out: a forward channel carrying broadcast requests and writeback ack/nack, a response channel carrying data to a requestor, and a memory command channel carrying reads and writes. Each channel has a one-cycle-registered valid. Requests to a line that is busy are not consumed: the block signals a recycle, and the sender re-queues the request.

Stable states are not-owner (`LS_NO`), owner (`LS_OW`) and exclusive-owner (`LS_EX`). The transient states are:
- `LS_NO_BLK` and `LS_OW_BLK`: waiting for unblock only.
- `LS_NO_BLK_MW` and `LS_OW_BLK_MW`: waiting for unblock and memory data.
- `LS_NO_MW` and `LS_OW_MW`: waiting for memory data only.
- `LS_WB`: waiting for a writeback.
- `LS_WB_TO_EX` and `LS_WB_TO_OW`: waiting for the memory write ack.

Transitions:
- A read in `LS_EX` goes to `LS_NO_BLK_MW`.
- A read-exclusive in `LS_OW` goes to `LS_NO_BLK_MW`; a read-shared in `LS_OW` goes to `LS_OW_BLK_MW`.
- A read in `LS_NO` goes to `LS_NO_BLK`.
- A put in `LS_NO` goes to `LS_WB`.
- Unblock moves a `_BLK` state to its stable state, and a `_BLK_MW` state to its `_MW` state.
- Memory data moves a `_BLK_MW` state to its `_BLK` state, and a `_MW` state to its stable state.
- In `LS_WB`: dirty goes to `LS_WB_TO_EX`, exclusive-dirty to `LS_WB_TO_OW`, clean to `LS_OW`, exclusive-clean to `LS_EX`, unblock to `LS_NO`.
- Write ack ends `LS_WB_TO_EX` in `LS_EX` and `LS_WB_TO_OW` in `LS_OW`.

Top module: `dir_line_ctrl`

## Requirements
- R1: After reset every line is in `LS_EX` with no open record, and no output valid or error is raised.
- R2: A read (req_kind 0 = read-shared, 1 = read-exclusive) to an `LS_EX` line opens a record marked exclusive, issues a memory read (mcmd_write 0, mcmd_dest = requestor), forwards the request, and moves the line to `LS_NO_BLK_MW`.
- R3: In `LS_OW`, read-exclusive moves the line to `LS_NO_BLK_MW` and read-shared moves it to `LS_OW_BLK_MW`. In both cases a memory read is issued and the record is marked plain data.
- R4: A read to an `LS_NO` line is forwarded, issues no memory read, and moves the line to `LS_NO_BLK`.
- R5: A forward carries fwd_kind 0 for read-shared or 1 for read-exclusive. Its fwd_mask has every cache bit set except the requestor's bit. A forward is emitted only when NCACHE > 1.
- R6: A put (req_kind 2) in `LS_NO` sends a writeback ack (fwd_kind 2) and moves the line to `LS_WB`. A put in `LS_OW` or `LS_EX` sends a nack (fwd_kind 3) and leaves the state unchanged. Ack and nack are sent with a one-hot fwd_mask on the requestor.
- R7: A valid request to a line in any transient state asserts req_recycle and not req_take, and leaves the line unchanged.
- R8: Memory read data (mem_kind 0) in a `_BLK_MW` state sends a data response to mem_dest, frees the record and drops to the matching `_BLK` state. A later unblock (ubl_kind 0) returns the line to its stable state.
- R9: An unblock in a `_BLK_MW` state moves the line to its `_MW` state. The memory data that follows frees the record, sends no response, and returns the line to `LS_NO` or `LS_OW`.
- R10: In `LS_WB`:
  - ubl_kind 2 (dirty) issues a memory write of ubl_data and ends in `LS_EX` after the write ack (mem_kind 1).
  - ubl_kind 4 (exclusive dirty) does the same but ends in `LS_OW`.
  - ubl_kind 1 (clean) goes straight to `LS_OW`.
  - ubl_kind 3 (exclusive clean) goes straight to `LS_EX`.
  - ubl_kind 0 goes to `LS_NO`.
- R11: Every data response has rsp_dirty 0 and rsp_acks 1. rsp_excl is set exactly when the record was opened in `LS_EX`.
- R12: Channel priority is memory, then unblock/writeback, then request. At most one message is taken or recycled per cycle, and the take strobes are combinational in the cycle a message is presented.
- R13: A memory or unblock message that does not fit the line state, and any request of reserved kind 3, is consumed. It raises err for one cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request present |
| req_kind | input | 2 | 0 read-shared, 1 read-exclusive, 2 put, 3 reserved |
| req_line | input | IDX_W | line index |
| req_src | input | ID_W | requesting cache |
| req_take | output | 1 | request consumed this cycle |
| req_recycle | output | 1 | request must be re-queued |
| ubl_valid | input | 1 | unblock/writeback present |
| ubl_kind | input | 3 | 0 unblock, 1 clean, 2 dirty, 3 excl clean, 4 excl dirty |
| ubl_line | input | IDX_W | line index |
| ubl_data | input | DATA_W | writeback data |
| ubl_take | output | 1 | unblock/writeback consumed |
| mem_valid | input | 1 | memory reply present |
| mem_kind | input | 1 | 0 read data, 1 write ack |
| mem_line | input | IDX_W | line index |
| mem_dest | input | ID_W | original requestor of the read |
| mem_data | input | DATA_W | read data |
| mem_take | output | 1 | memory reply consumed |
| fwd_valid | output | 1 | forward channel message |
| fwd_kind | output | 2 | 0 fwd shared, 1 fwd excl, 2 wb ack, 3 wb nack |
| fwd_line | output | IDX_W | line index |
| fwd_src | output | ID_W | original requestor |
| fwd_mask | output | NCACHE | destination caches |
| rsp_valid | output | 1 | data response |
| rsp_excl | output | 1 | exclusive-data type |
| rsp_line | output | IDX_W | line index |
| rsp_dest | output | ID_W | destination cache |
| rsp_data | output | DATA_W | data |
| rsp_dirty | output | 1 | dirty flag, always 0 |
| rsp_acks | output | 2 | ack count, always 1 |
| mcmd_valid | output | 1 | memory command |
| mcmd_write | output | 1 | 1 write, 0 read |
| mcmd_line | output | IDX_W | line index |
| mcmd_dest | output | ID_W | requestor for reads |
| mcmd_data | output | DATA_W | write data |
| err | output | 1 | unexpected message seen last cycle |

## Verification
The bench drives both arrival orders of unblock and memory data, and checks the responses and final states. A design that swapped the orders would send a duplicate response, or none. The bench sends requests to every transient state, where an incorrect design would consume them and corrupt ownership. It covers all four writeback kinds, where swapping the dirty end states would later show up as an exclusive-data response where plain data was expected. Simultaneous arrivals on all channels expose a priority mistake, and misfit messages expose an error path that changes state.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
    typedef enum logic [3:0] {
        LS_NO, LS_OW, LS_EX, LS_NO_BLK, LS_OW_BLK, LS_NO_BLK_MW, LS_OW_BLK_MW,
        LS_NO_MW, LS_OW_MW, LS_WB, LS_WB_TO_OW, LS_WB_TO_EX
    } line_st_e;

    typedef enum logic [1:0] {CH_NONE, CH_MEM, CH_UBL, CH_REQ} chan_e;

    localparam logic [1:0] RQ_RD_SH = 2'd0;
    localparam logic [1:0] RQ_RD_EX = 2'd1;
    localparam logic [1:0] RQ_PUT   = 2'd2;

    localparam logic [2:0] UB_UNBLK  = 3'd0;
    localparam logic [2:0] UB_CLEAN  = 3'd1;
    localparam logic [2:0] UB_DIRTY  = 3'd2;
    localparam logic [2:0] UB_XCLEAN = 3'd3;
    localparam logic [2:0] UB_XDIRTY = 3'd4;

    localparam logic MK_RDATA = 1'b0;

    localparam logic [1:0] FK_SH   = 2'd0;
    localparam logic [1:0] FK_EX   = 2'd1;
    localparam logic [1:0] FK_ACK  = 2'd2;
    localparam logic [1:0] FK_NACK = 2'd3;

    typedef struct packed {
        logic       fwd;
        logic [1:0] fwd_kind;
        logic       rsp;
        logic       mrd;
        logic       mwr;
        logic       rec_open;
        logic       rec_x;
        logic       rec_free;
        logic       recycle;
        logic       err;
        line_st_e   nxt;
    } act_t;
endpackage

// File: rtl/dirc_arb.sv
module dirc_arb
    import dirc_pkg::*;
(
    input  logic  rst_n,
    input  logic  mem_valid,
    input  logic  ubl_valid,
    input  logic  req_valid,
    output chan_e ch
);
    always_comb begin
        if (!rst_n)         ch = CH_NONE;
        else if (mem_valid) ch = CH_MEM;
        else if (ubl_valid) ch = CH_UBL;
        else if (req_valid) ch = CH_REQ;
        else                ch = CH_NONE;
    end
endmodule

// File: rtl/dirc_next.sv
module dirc_next
    import dirc_pkg::*;
(
    input  chan_e      ch,
    input  line_st_e   cur,
    input  logic       rec_v,
    input  logic [1:0] req_kind,
    input  logic [2:0] ubl_kind,
    input  logic       mem_kind,
    output act_t       act
);
    always_comb begin
        act     = '0;
        act.nxt = cur;
        unique case (ch)
            CH_MEM: begin
                if (mem_kind == MK_RDATA) begin
                    unique case (cur)
                        LS_NO_BLK_MW, LS_OW_BLK_MW: begin
                            if (rec_v) begin
                                act.rsp      = 1'b1;
                                act.rec_free = 1'b1;
                                act.nxt      = (cur == LS_NO_BLK_MW) ? LS_NO_BLK : LS_OW_BLK;
                            end else begin
                                act.err = 1'b1;
                            end
                        end
                        LS_NO_MW, LS_OW_MW: begin
                            if (rec_v) begin
                                act.rec_free = 1'b1;
                                act.nxt      = (cur == LS_NO_MW) ? LS_NO : LS_OW;
                            end else begin
                                act.err = 1'b1;
                            end
                        end
                        default: act.err = 1'b1;
                    endcase
                end else begin
                    unique case (cur)
                        LS_WB_TO_EX: act.nxt = LS_EX;
                        LS_WB_TO_OW: act.nxt = LS_OW;
                        default:     act.err = 1'b1;
                    endcase
                end
            end
            CH_UBL: begin
                unique case (cur)
                    LS_NO_BLK:    if (ubl_kind == UB_UNBLK) act.nxt = LS_NO;    else act.err = 1'b1;
                    LS_OW_BLK:    if (ubl_kind == UB_UNBLK) act.nxt = LS_OW;    else act.err = 1'b1;
                    LS_NO_BLK_MW: if (ubl_kind == UB_UNBLK) act.nxt = LS_NO_MW; else act.err = 1'b1;
                    LS_OW_BLK_MW: if (ubl_kind == UB_UNBLK) act.nxt = LS_OW_MW; else act.err = 1'b1;
                    LS_WB: begin
                        unique case (ubl_kind)
                            UB_UNBLK:  act.nxt = LS_NO;
                            UB_CLEAN:  act.nxt = LS_OW;
                            UB_XCLEAN: act.nxt = LS_EX;
                            UB_DIRTY:  begin act.mwr = 1'b1; act.nxt = LS_WB_TO_EX; end
                            UB_XDIRTY: begin act.mwr = 1'b1; act.nxt = LS_WB_TO_OW; end
                            default:   act.err = 1'b1;
                        endcase
                    end
                    default: act.err = 1'b1;
                endcase
            end
            CH_REQ: begin
                if (req_kind == 2'd3) begin
                    act.err = 1'b1;
                end else begin
                    unique case (cur)
                        LS_EX: begin
                            if (req_kind == RQ_PUT) begin
                                act.fwd = 1'b1; act.fwd_kind = FK_NACK;
                            end else begin
                                act.rec_open = 1'b1; act.rec_x = 1'b1; act.mrd = 1'b1;
                                act.fwd = 1'b1;
                                act.fwd_kind = (req_kind == RQ_RD_EX) ? FK_EX : FK_SH;
                                act.nxt = LS_NO_BLK_MW;
                            end
                        end
                        LS_OW: begin
                            if (req_kind == RQ_PUT) begin
                                act.fwd = 1'b1; act.fwd_kind = FK_NACK;
                            end else begin
                                act.rec_open = 1'b1; act.mrd = 1'b1; act.fwd = 1'b1;
                                act.fwd_kind = (req_kind == RQ_RD_EX) ? FK_EX : FK_SH;
                                act.nxt = (req_kind == RQ_RD_EX) ? LS_NO_BLK_MW : LS_OW_BLK_MW;
                            end
                        end
                        LS_NO: begin
                            act.fwd = 1'b1;
                            if (req_kind == RQ_PUT) begin
                                act.fwd_kind = FK_ACK;
                                act.nxt = LS_WB;
                            end else begin
                                act.fwd_kind = (req_kind == RQ_RD_EX) ? FK_EX : FK_SH;
                                act.nxt = LS_NO_BLK;
                            end
                        end
                        default: act.recycle = 1'b1;
                    endcase
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dirc_table.sv
module dirc_table
    import dirc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output line_st_e         rd_st,
    output logic             rd_rv,
    output logic             rd_rx,
    input  logic             we,
    input  line_st_e         wst,
    input  logic             rec_open,
    input  logic             rec_x,
    input  logic             rec_free
);
    localparam int LINES = 1 << IDX_W;

    line_st_e   st_all [LINES];
    logic [LINES-1:0] rv_all;
    logic [LINES-1:0] rx_all;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_st_e st_q;
        logic     rv_q;
        logic     rx_q;
        logic     hit;
        assign hit = we && (idx == IDX_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= LS_EX;
                rv_q <= 1'b0;
                rx_q <= 1'b0;
            end else if (hit) begin
                st_q <= wst;
                if (rec_open) begin
                    rv_q <= 1'b1;
                    rx_q <= rec_x;
                end else if (rec_free) begin
                    rv_q <= 1'b0;
                end
            end
        end
        assign st_all[i] = st_q;
        assign rv_all[i] = rv_q;
        assign rx_all[i] = rx_q;
    end

    assign rd_st = st_all[idx];
    assign rd_rv = rv_all[idx];
    assign rd_rx = rx_all[idx];
endmodule

// File: rtl/dirc_outreg.sv
module dirc_outreg #(
    parameter int NCACHE = 4,
    parameter int IDX_W  = 3,
    parameter int ID_W   = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_en,
    input  logic [1:0]        f_kind,
    input  logic              f_bcast,
    input  logic [IDX_W-1:0]  f_line,
    input  logic [ID_W-1:0]   f_src,
    input  logic              r_en,
    input  logic              r_excl,
    input  logic [IDX_W-1:0]  r_line,
    input  logic [ID_W-1:0]   r_dest,
    input  logic [DATA_W-1:0] r_data,
    input  logic              m_en,
    input  logic              m_wr,
    input  logic [IDX_W-1:0]  m_line,
    input  logic [ID_W-1:0]   m_dest,
    input  logic [DATA_W-1:0] m_data,
    input  logic              e_en,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [IDX_W-1:0]  fwd_line,
    output logic [ID_W-1:0]   fwd_src,
    output logic [NCACHE-1:0] fwd_mask,
    output logic              rsp_valid,
    output logic              rsp_excl,
    output logic [IDX_W-1:0]  rsp_line,
    output logic [ID_W-1:0]   rsp_dest,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic [1:0]        rsp_acks,
    output logic              mcmd_valid,
    output logic              mcmd_write,
    output logic [IDX_W-1:0]  mcmd_line,
    output logic [ID_W-1:0]   mcmd_dest,
    output logic [DATA_W-1:0] mcmd_data,
    output logic              err
);
    logic [NCACHE-1:0] onehot;
    assign onehot = NCACHE'(1) << f_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0; fwd_kind <= '0; fwd_line <= '0; fwd_src <= '0; fwd_mask <= '0;
            rsp_valid <= 1'b0; rsp_excl <= 1'b0; rsp_line <= '0; rsp_dest <= '0;
            rsp_data <= '0; rsp_dirty <= 1'b0; rsp_acks <= '0;
            mcmd_valid <= 1'b0; mcmd_write <= 1'b0; mcmd_line <= '0; mcmd_dest <= '0;
            mcmd_data <= '0; err <= 1'b0;
        end else begin
            fwd_valid  <= f_en;
            fwd_kind   <= f_kind;
            fwd_line   <= f_line;
            fwd_src    <= f_src;
            fwd_mask   <= f_bcast ? ~onehot : onehot;
            rsp_valid  <= r_en;
            rsp_excl   <= r_excl;
            rsp_line   <= r_line;
            rsp_dest   <= r_dest;
            rsp_data   <= r_data;
            rsp_dirty  <= 1'b0;
            rsp_acks   <= 2'd1;
            mcmd_valid <= m_en;
            mcmd_write <= m_wr;
            mcmd_line  <= m_line;
            mcmd_dest  <= m_dest;
            mcmd_data  <= m_data;
            err        <= e_en;
        end
    end
endmodule

// File: rtl/dir_line_ctrl.sv
module dir_line_ctrl
    import dirc_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16,
    localparam int ID_W  = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [IDX_W-1:0]  req_line,
    input  logic [ID_W-1:0]   req_src,
    output logic              req_take,
    output logic              req_recycle,
    input  logic              ubl_valid,
    input  logic [2:0]        ubl_kind,
    input  logic [IDX_W-1:0]  ubl_line,
    input  logic [DATA_W-1:0] ubl_data,
    output logic              ubl_take,
    input  logic              mem_valid,
    input  logic              mem_kind,
    input  logic [IDX_W-1:0]  mem_line,
    input  logic [ID_W-1:0]   mem_dest,
    input  logic [DATA_W-1:0] mem_data,
    output logic              mem_take,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [IDX_W-1:0]  fwd_line,
    output logic [ID_W-1:0]   fwd_src,
    output logic [NCACHE-1:0] fwd_mask,
    output logic              rsp_valid,
    output logic              rsp_excl,
    output logic [IDX_W-1:0]  rsp_line,
    output logic [ID_W-1:0]   rsp_dest,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic [1:0]        rsp_acks,
    output logic              mcmd_valid,
    output logic              mcmd_write,
    output logic [IDX_W-1:0]  mcmd_line,
    output logic [ID_W-1:0]   mcmd_dest,
    output logic [DATA_W-1:0] mcmd_data,
    output logic              err
);
    chan_e            ch;
    act_t             act;
    line_st_e         cur_st;
    logic             cur_rv;
    logic             cur_rx;
    logic [IDX_W-1:0] sel_line;
    logic             bcast_ok;
    logic             f_en;

    dirc_arb u_arb (
        .rst_n(rst_n), .mem_valid(mem_valid), .ubl_valid(ubl_valid),
        .req_valid(req_valid), .ch(ch)
    );

    always_comb begin
        unique case (ch)
            CH_MEM:  sel_line = mem_line;
            CH_UBL:  sel_line = ubl_line;
            default: sel_line = req_line;
        endcase
    end

    dirc_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .idx(sel_line),
        .rd_st(cur_st), .rd_rv(cur_rv), .rd_rx(cur_rx),
        .we(ch != CH_NONE), .wst(act.nxt),
        .rec_open(act.rec_open), .rec_x(act.rec_x), .rec_free(act.rec_free)
    );

    dirc_next u_next (
        .ch(ch), .cur(cur_st), .rec_v(cur_rv), .req_kind(req_kind),
        .ubl_kind(ubl_kind), .mem_kind(mem_kind), .act(act)
    );

    assign mem_take    = (ch == CH_MEM);
    assign ubl_take    = (ch == CH_UBL);
    assign req_take    = (ch == CH_REQ) && !act.recycle;
    assign req_recycle = (ch == CH_REQ) && act.recycle;

    if (NCACHE > 1) begin : g_multi
        assign bcast_ok = 1'b1;
    end else begin : g_single
        assign bcast_ok = 1'b0;
    end

    assign f_en = act.fwd && (act.fwd_kind[1] || bcast_ok);

    dirc_outreg #(.NCACHE(NCACHE), .IDX_W(IDX_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .f_en(f_en), .f_kind(act.fwd_kind), .f_bcast(!act.fwd_kind[1]),
        .f_line(req_line), .f_src(req_src),
        .r_en(act.rsp), .r_excl(cur_rx), .r_line(mem_line), .r_dest(mem_dest), .r_data(mem_data),
        .m_en(act.mrd || act.mwr), .m_wr(act.mwr),
        .m_line(act.mwr ? ubl_line : req_line),
        .m_dest(act.mwr ? '0 : req_src),
        .m_data(act.mwr ? ubl_data : '0),
        .e_en(act.err),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_line(fwd_line), .fwd_src(fwd_src),
        .fwd_mask(fwd_mask), .rsp_valid(rsp_valid), .rsp_excl(rsp_excl), .rsp_line(rsp_line),
        .rsp_dest(rsp_dest), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty), .rsp_acks(rsp_acks),
        .mcmd_valid(mcmd_valid), .mcmd_write(mcmd_write), .mcmd_line(mcmd_line),
        .mcmd_dest(mcmd_dest), .mcmd_data(mcmd_data), .err(err)
    );
endmodule

// File: rtl/dirc_chk.sv
module dirc_chk #(
    parameter int NCACHE = 4,
    parameter int ID_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_kind,
    input logic              mem_take,
    input logic              ubl_valid,
    input logic [2:0]        ubl_kind,
    input logic              ubl_take,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              req_take,
    input logic              req_recycle,
    input logic              fwd_valid,
    input logic [1:0]        fwd_kind,
    input logic [ID_W-1:0]   fwd_src,
    input logic [NCACHE-1:0] fwd_mask,
    input logic              rsp_valid,
    input logic              mcmd_valid,
    input logic              mcmd_write,
    input logic              err
);
    a_r12_one_consume: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_take, ubl_take, req_take, req_recycle}) <= 1);

    a_r12_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_take);

    a_r12_ubl_second: assert property (@(posedge clk) disable iff (!rst_n)
        (ubl_valid && !mem_valid) |-> ubl_take);

    a_r7_req_last: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_valid && !ubl_valid) |-> (req_take || req_recycle));

    a_r5_fwd_excludes_src: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_kind[1]) |-> (!fwd_mask[fwd_src] && $countones(fwd_mask) == NCACHE - 1));

    a_r6_ack_to_putter: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_kind[1]) |-> ($onehot0(fwd_mask) && fwd_mask[fwd_src]
                                        && $past(req_take && req_kind == 2'd2)));

    a_r8_rsp_after_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_take && !mem_kind));

    a_r2_mrd_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mcmd_valid && !mcmd_write) |-> $past(req_take));

    a_r10_mwr_after_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (mcmd_valid && mcmd_write) |-> $past(ubl_take && (ubl_kind == 3'd2 || ubl_kind == 3'd4)));

    a_r13_err_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(mem_take || ubl_take || req_take));
endmodule

bind dir_line_ctrl dirc_chk #(.NCACHE(NCACHE), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_kind(mem_kind), .mem_take(mem_take),
    .ubl_valid(ubl_valid), .ubl_kind(ubl_kind), .ubl_take(ubl_take),
    .req_valid(req_valid), .req_kind(req_kind), .req_take(req_take), .req_recycle(req_recycle),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_src(fwd_src), .fwd_mask(fwd_mask),
    .rsp_valid(rsp_valid), .mcmd_valid(mcmd_valid), .mcmd_write(mcmd_write), .err(err)
);

// File: tb/tb_dir_line_ctrl.sv
module tb_dir_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCACHE = 4;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 16;
    localparam int ID_W   = 2;
    localparam int LINES  = 8;

    localparam int S_NO = 0, S_OW = 1, S_EX = 2, S_NOB = 3, S_OWB = 4, S_NOBM = 5,
                   S_OWBM = 6, S_NOM = 7, S_OWM = 8, S_WB = 9, S_WBO = 10, S_WBE = 11;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0; logic [1:0] req_kind = 0; logic [IDX_W-1:0] req_line = 0; logic [ID_W-1:0] req_src = 0;
    logic ubl_valid = 0; logic [2:0] ubl_kind = 0; logic [IDX_W-1:0] ubl_line = 0; logic [DATA_W-1:0] ubl_data = 0;
    logic mem_valid = 0; logic mem_kind = 0; logic [IDX_W-1:0] mem_line = 0; logic [ID_W-1:0] mem_dest = 0;
    logic [DATA_W-1:0] mem_data = 0;
    logic req_take, req_recycle, ubl_take, mem_take;
    logic fwd_valid; logic [1:0] fwd_kind; logic [IDX_W-1:0] fwd_line; logic [ID_W-1:0] fwd_src;
    logic [NCACHE-1:0] fwd_mask;
    logic rsp_valid, rsp_excl, rsp_dirty; logic [IDX_W-1:0] rsp_line; logic [ID_W-1:0] rsp_dest;
    logic [DATA_W-1:0] rsp_data; logic [1:0] rsp_acks;
    logic mcmd_valid, mcmd_write; logic [IDX_W-1:0] mcmd_line; logic [ID_W-1:0] mcmd_dest;
    logic [DATA_W-1:0] mcmd_data; logic err;

    dir_line_ctrl #(.NCACHE(NCACHE), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    int mst [LINES];
    bit mrx [LINES];

    // expected outputs of the reference model
    logic [3:0]   e_take;
    logic [127:0] e_out;
    int           n_line, n_st;
    bit           n_open, n_x;

    function automatic logic [127:0] pack(
        logic fv, logic [1:0] fk, logic [IDX_W-1:0] fl, logic [ID_W-1:0] fs, logic [NCACHE-1:0] fm,
        logic rv, logic rx, logic [IDX_W-1:0] rl, logic [ID_W-1:0] rd, logic [DATA_W-1:0] rdat,
        logic rdirty, logic [1:0] racks,
        logic mv, logic mw, logic [IDX_W-1:0] ml, logic [ID_W-1:0] md, logic [DATA_W-1:0] mdat,
        logic er);
        logic [127:0] v;
        v = '0;
        if (fv) v[15:0] = {1'b1, 2'(fk), 3'(fl), 2'(fs), 4'(fm), 4'd0};
        if (rv) v[55:16] = {1'b1, rx, 3'(rl), 2'(rd), 16'(rdat), rdirty, 2'(racks), 14'd0};
        if (mv) v[95:56] = {1'b1, mw, 3'(ml), 2'(md), 16'(mdat), 17'd0};
        v[96] = er;
        return v;
    endfunction

    task automatic model_eval();
        logic fv, rv, mv, mw, rx, er;
        logic [1:0] fk; logic [NCACHE-1:0] fm; logic [DATA_W-1:0] mdat; logic [ID_W-1:0] md;
        logic [IDX_W-1:0] ml;
        int s;
        fv = 0; rv = 0; mv = 0; mw = 0; rx = 0; er = 0; fk = 0; fm = 0; mdat = 0; md = 0; ml = 0;
        e_take = 4'b0000; n_line = -1; n_st = 0; n_open = 0; n_x = 0;
        if (mem_valid) begin
            e_take = 4'b1000; n_line = mem_line; s = mst[mem_line]; n_st = s;
            if (mem_kind == 0) begin
                if (s == S_NOBM || s == S_OWBM) begin
                    rv = 1; rx = mrx[mem_line]; n_st = (s == S_NOBM) ? S_NOB : S_OWB;
                end else if (s == S_NOM) n_st = S_NO;
                else if (s == S_OWM) n_st = S_OW;
                else er = 1;
            end else begin
                if (s == S_WBE) n_st = S_EX; else if (s == S_WBO) n_st = S_OW; else er = 1;
            end
        end else if (ubl_valid) begin
            e_take = 4'b0100; n_line = ubl_line; s = mst[ubl_line]; n_st = s;
            if (s == S_WB) begin
                case (ubl_kind)
                    0: n_st = S_NO;
                    1: n_st = S_OW;
                    3: n_st = S_EX;
                    2: begin n_st = S_WBE; mv = 1; mw = 1; ml = ubl_line; mdat = ubl_data; end
                    4: begin n_st = S_WBO; mv = 1; mw = 1; ml = ubl_line; mdat = ubl_data; end
                    default: er = 1;
                endcase
            end else if (ubl_kind == 0 && s == S_NOB) n_st = S_NO;
            else if (ubl_kind == 0 && s == S_OWB) n_st = S_OW;
            else if (ubl_kind == 0 && s == S_NOBM) n_st = S_NOM;
            else if (ubl_kind == 0 && s == S_OWBM) n_st = S_OWM;
            else er = 1;
        end else if (req_valid) begin
            n_line = req_line; s = mst[req_line]; n_st = s;
            if (req_kind == 3) begin
                e_take = 4'b0010; er = 1;
            end else if (s != S_NO && s != S_OW && s != S_EX) begin
                e_take = 4'b0001;
            end else begin
                e_take = 4'b0010;
                if (req_kind == 2) begin
                    fv = 1; fm = NCACHE'(1) << req_src;
                    if (s == S_NO) begin fk = 2; n_st = S_WB; end else fk = 3;
                end else begin
                    fv = 1; fk = req_kind; fm = ~(NCACHE'(1) << req_src);
                    if (s == S_NO) n_st = S_NOB;
                    else begin
                        mv = 1; ml = req_line; md = req_src; n_open = 1; n_x = (s == S_EX);
                        n_st = (s == S_OW && req_kind == 0) ? S_OWBM : S_NOBM;
                    end
                end
            end
        end
        e_out = pack(fv, fk, req_line, req_src, fm, rv, rx, mem_line, mem_dest, mem_data, 1'b0, 2'd1,
                     mv, mw, ml, md, mdat, er);
    endtask

    task automatic step(string tag);
        logic [3:0] got_t;
        logic [127:0] got_o;
        #1;
        model_eval();
        got_t = {mem_take, ubl_take, req_take, req_recycle};
        checks++;
        if (got_t !== e_take) begin
            errors++;
            $display("FAIL %s take/recycle got %b expected %b", tag, got_t, e_take);
        end
        @(posedge clk);
        if (n_line >= 0) begin
            mst[n_line] = n_st;
            if (n_open) mrx[n_line] = n_x;
        end
        @(negedge clk);
        req_valid = 0; ubl_valid = 0; mem_valid = 0;
        got_o = pack(fwd_valid, fwd_kind, fwd_line, fwd_src, fwd_mask, rsp_valid, rsp_excl, rsp_line,
                     rsp_dest, rsp_data, rsp_dirty, rsp_acks, mcmd_valid, mcmd_write, mcmd_line,
                     mcmd_dest, mcmd_data, err);
        checks++;
        if (got_o !== e_out) begin
            errors++;
            $display("FAIL %s outputs got %h expected %h", tag, got_o, e_out);
        end
    endtask

    task automatic t_req(input int k, input int l, input int s);
        req_valid = 1; req_kind = 2'(k); req_line = IDX_W'(l); req_src = ID_W'(s);
    endtask
    task automatic t_ubl(input int k, input int l, input int d);
        ubl_valid = 1; ubl_kind = 3'(k); ubl_line = IDX_W'(l); ubl_data = DATA_W'(d);
    endtask
    task automatic t_mem(input int k, input int l, input int dst, input int d);
        mem_valid = 1; mem_kind = 1'(k); mem_line = IDX_W'(l); mem_dest = ID_W'(dst); mem_data = DATA_W'(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin mst[i] = S_EX; mrx[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R1");                                     // idle after reset
        // line 0: exclusive read, memory data first
        t_req(0, 0, 1);            step("R2");
        t_req(0, 0, 2);            step("R7");
        t_mem(0, 0, 1, 'hAAAA);    step("R8");
        t_req(1, 0, 2);            step("R7");
        t_ubl(0, 0, 0);            step("R8");
        t_req(1, 0, 2);            step("R4");
        t_ubl(0, 0, 0);            step("R4");
        t_req(2, 0, 3);            step("R6");
        t_req(0, 0, 0);            step("R7");
        t_ubl(2, 0, 'h1234);       step("R10");
        t_req(0, 0, 0);            step("R7");
        t_mem(1, 0, 0, 0);         step("R10");
        t_req(0, 0, 0);            step("R10");         // back in exclusive: memory read issued
        t_ubl(0, 0, 0);            step("R9");
        t_req(0, 0, 1);            step("R7");
        t_mem(0, 0, 0, 'h0F0F);    step("R9");          // no response expected
        t_req(0, 0, 1);            step("R5");          // now not-owner: forward only
        t_ubl(0, 0, 0);            step("R4");
        // line 1: nack, owner paths
        t_req(2, 1, 0);            step("R6");
        t_req(1, 1, 0);            step("R2");
        t_mem(0, 1, 0, 'h1111);    step("R11");
        t_ubl(0, 1, 0);            step("R8");
        t_req(2, 1, 0);            step("R6");
        t_ubl(1, 1, 0);            step("R10");
        t_req(2, 1, 2);            step("R6");
        t_req(0, 1, 2);            step("R3");
        t_ubl(0, 1, 0);            step("R9");
        t_mem(0, 1, 2, 'h2222);    step("R9");
        t_req(0, 1, 3);            step("R3");
        t_mem(0, 1, 3, 'h3333);    step("R11");
        t_ubl(0, 1, 0);            step("R8");
        t_req(1, 1, 3);            step("R3");
        t_mem(0, 1, 3, 'h4444);    step("R11");
        t_ubl(0, 1, 0);            step("R8");
        // line 2: exclusive dirty writeback ends owner
        t_req(1, 2, 1);            step("R2");
        t_mem(0, 2, 1, 'h5151);    step("R8");
        t_ubl(0, 2, 0);            step("R8");
        t_req(2, 2, 1);            step("R6");
        t_ubl(4, 2, 'h5555);       step("R10");
        t_mem(1, 2, 0, 0);         step("R10");
        t_req(0, 2, 2);            step("R10");         // owner: plain data pending
        t_mem(0, 2, 2, 'h6666);    step("R11");
        t_ubl(0, 2, 0);            step("R8");
        // line 3: exclusive clean writeback ends exclusive
        t_req(1, 3, 2);            step("R2");
        t_mem(0, 3, 2, 'h7777);    step("R8");
        t_ubl(0, 3, 0);            step("R8");
        t_req(2, 3, 2);            step("R6");
        t_ubl(3, 3, 0);            step("R10");
        t_req(0, 3, 1);            step("R10");
        t_mem(0, 3, 1, 'h8888);    step("R11");
        t_ubl(0, 3, 0);            step("R8");
        // line 3 via plain unblock from writeback
        t_req(2, 3, 0);            step("R6");
        t_ubl(0, 3, 0);            step("R10");
        t_req(0, 3, 2);            step("R4");
        t_ubl(0, 3, 0);            step("R4");
        // priority: all three channels at once
        t_mem(0, 4, 0, 'h9999); t_ubl(0, 5, 0); t_req(0, 6, 1); step("R12");
        t_ubl(0, 5, 0); t_req(0, 6, 1);                         step("R12");
        t_req(0, 6, 1);                                         step("R12");
        // misfit messages
        t_mem(1, 0, 0, 0);         step("R13");
        t_ubl(6, 0, 0);            step("R13");
        t_req(3, 0, 1);            step("R13");
        t_mem(0, 5, 0, 'hABCD);    step("R13");
        t_req(0, 0, 2);            step("R13");         // line 0 still not-owner
        t_ubl(0, 0, 0);            step("R13");
        t_req(0, 5, 3);            step("R13");         // line 5 still exclusive
        step("R1");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule